// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an EDO DRAM's contents alive and brings the part up after power-on. Out of reset it stays quiet for a programmable pause. It then wins the strobe bus from the access controller through a request/grant pair and runs a burst of column-before-row refresh cycles. Only after that burst does it raise `init_done_o`. The access controller must not accept host traffic until this flag is high.

In normal operation a free-running interval timer adds one refresh to a pending count each period. While the count is non-zero the block requests the bus. Each time it is granted and idle, it runs one refresh cycle and lowers the count. A grant that arrives late is served back to back until the backlog is gone. The count saturates, so a very long denial cannot wrap it.

When the low-power request `sr_req_i` is raised, the block runs one guard refresh first. It then parks the DRAM in self-refresh: the row strobe is held low with both column strobes low, for at least a minimum width, and for as long as the request stays high. On exit it observes the longer self-refresh precharge, runs a second guard refresh, and restarts the interval timer from zero. All widths are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, `ras_n_o` is 1, every bit of `cas_n_o` is 1, `bus_req_o` is 0 and `init_done_o` is 0.
- R2: For INIT_PAUSE_CYC cycles after reset is released, the block neither requests the bus nor drives any strobe low.
- R3: After the pause, the block runs exactly INIT_REFRESHES refresh cycles while granted. `init_done_o` rises only after the last one has finished its precharge, with `ras_n_o` high, and it stays high afterwards.
- R4: In every refresh cycle, all column strobe lanes fall together and are low for exactly CSR_CYC cycles before `ras_n_o` falls. They stay low for exactly CHR_CYC cycles after it falls. The lanes never differ in value.
- R5: In a normal refresh, `ras_n_o` is low for exactly RAS_CYC cycles. It is then high for at least RP_CYC cycles before it falls again.
- R6: After initialisation, with the grant held, successive refresh cycles start exactly REF_INTERVAL_CYC cycles apart.
- R7: Without a grant, no strobe is driven low and `bus_req_o` stays high while refreshes are owed. When the grant returns, each refresh missed during the denial is run back to back.
- R8: The owed count saturates at 2^PEND_W-1. A denial longer than that many intervals yields exactly that many catch-up cycles, plus at most one newly timed one.
- R9: While `sr_req_i` is high, the block first runs one normal refresh. It then holds `ras_n_o` low with all column lanes low. The row strobe stays low for at least SELF_MIN_CYC cycles, and for exactly SELF_MIN_CYC cycles when the request is dropped early.
- R10: After self-refresh ends, `ras_n_o` stays high for at least SELF_RP_CYC cycles. One guard refresh then follows, and the next timed refresh comes no sooner than REF_INTERVAL_CYC cycles after the bus is released.
- R11: Any strobe driven low implies `bus_req_o` high, and a refresh cycle starts only in a cycle after the grant was seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_gnt_i | input | 1 | Strobe bus granted to this block |
| sr_req_i | input | 1 | Request to hold the DRAM in self-refresh |
| bus_req_o | output | 1 | Strobe bus requested |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | LANES | Column strobes, one per byte lane, active low |
| init_done_o | output | 1 | Power-up sequence complete; host accesses allowed |

## Verification
A corrupted phase counter shows up at the ports within one refresh cycle. It appears as a wrong column setup, column hold or row-low width, which the bench measures from edge to edge. A faulty interval timer or owed-count register is harder to see. It shows only as refresh starts spaced wrongly, or as a wrong number of catch-up cycles after a grant returns, so it is visible one interval after the fault, or after a denial. Errors in the self-refresh steps show as a missing guard cycle, a short parked row strobe, a short precharge, or a timer that was not restarted. These appear within one interval of exit.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CSET, PH_CHOLD, PH_RLOW, PH_SELF, PH_PRE
  } dref_phase_e;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_INIT, ST_RUN, ST_GIN, ST_SELF, ST_GOUT
  } dref_state_e;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int REF_INTERVAL_CYC = 780,
  parameter int PEND_W           = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              dec_i,
  output logic [PEND_W-1:0] pend_o
);
  localparam int TW = $clog2(REF_INTERVAL_CYC + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [TW-1:0]     tick_q;
  logic [PEND_W-1:0] pend_q;
  logic              wrap;

  assign wrap = en_i && !clr_i && (tick_q == TW'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tick_q <= '0;
    else if (clr_i || wrap)       tick_q <= '0;
    else if (en_i)                tick_q <= tick_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              pend_q <= '0;
    else if (clr_i)                           pend_q <= '0;
    else if (wrap && !dec_i && pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
    else if (dec_i && !wrap)                  pend_q <= pend_q - 1'b1;
  end

  assign pend_o = pend_q;

  AST_DEC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> pend_q != '0); // R7
  AST_PEND_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PEND_MAX && !dec_i && !clr_i) |=> pend_q == PEND_MAX); // R8
endmodule

// File: rtl/dref_cbr_engine.sv
module dref_cbr_engine
  import dref_pkg::*;
#(
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 3,
  parameter int RP_CYC       = 2,
  parameter int SELF_MIN_CYC = 5000,
  parameter int SELF_RP_CYC  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic self_i,
  input  logic hold_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_low_o,
  output logic cas_low_o
);
  localparam int M1 = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int M2 = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int M3 = (SELF_MIN_CYC > SELF_RP_CYC) ? SELF_MIN_CYC : SELF_RP_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int CMAX = (M12 > M3) ? M12 : M3;
  localparam int CW = $clog2(CMAX + 1);

  dref_phase_e   ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          self_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin ph_d = PH_CSET; cnt_d = CW'(CSR_CYC - 1); end
      PH_CSET: if (last) begin
        if (self_q) begin ph_d = PH_SELF;  cnt_d = CW'(SELF_MIN_CYC - 1); end
        else        begin ph_d = PH_CHOLD; cnt_d = CW'(CHR_CYC - 1); end
      end
      PH_CHOLD: if (last) begin ph_d = PH_RLOW; cnt_d = CW'(RAS_CYC - CHR_CYC - 1); end
      PH_RLOW:  if (last) begin ph_d = PH_PRE;  cnt_d = CW'(RP_CYC - 1); end
      PH_SELF:  if (last && !hold_i) begin ph_d = PH_PRE; cnt_d = CW'(SELF_RP_CYC - 1); end
      PH_PRE:   if (last) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      self_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (ph_q == PH_IDLE && start_i) self_q <= self_i;
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = (ph_q == PH_PRE) && last;
  assign ras_low_o = (ph_q == PH_CHOLD) || (ph_q == PH_RLOW) || (ph_q == PH_SELF);
  assign cas_low_o = (ph_q == PH_CSET) || (ph_q == PH_CHOLD) || (ph_q == PH_SELF);

  // width checker: row-low cycles since the last fall
  logic [CW:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              low_run_q <= '0;
    else if (!ras_low_o)                      low_run_q <= '0;
    else if (low_run_q != {(CW+1){1'b1}})     low_run_q <= low_run_q + 1'b1;
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_low_o) |-> (cas_low_o && $past(cas_low_o))); // R4
  AST_NORMAL_RAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_low_o) && !self_q) |-> low_run_q == (CW+1)'(RAS_CYC)); // R5
  AST_SELF_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_low_o) && self_q) |-> low_run_q >= (CW+1)'(SELF_MIN_CYC)); // R9
  AST_NO_RESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_low_o) |=> !ras_low_o); // R5
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int LANES            = 2,
  parameter int INIT_PAUSE_CYC   = 10000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REF_INTERVAL_CYC = 780,
  parameter int PEND_W           = 3,
  parameter int CSR_CYC          = 1,
  parameter int CHR_CYC          = 1,
  parameter int RAS_CYC          = 3,
  parameter int RP_CYC           = 2,
  parameter int SELF_MIN_CYC     = 5000,
  parameter int SELF_RP_CYC      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_gnt_i,
  input  logic             sr_req_i,
  output logic             bus_req_o,
  output logic             ras_n_o,
  output logic [LANES-1:0] cas_n_o,
  output logic             init_done_o
);
  localparam int PW = $clog2(INIT_PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_REFRESHES + 1);

  dref_state_e       st_q, st_d;
  logic [PW-1:0]     pause_q;
  logic [IW-1:0]     icnt_q;
  logic              done_q;
  logic [PEND_W-1:0] pend;
  logic              start, eng_self, dec, tmr_clr;
  logic              busy, eng_done, ras_low, cas_low;
  logic              free;

  assign free = bus_gnt_i && !busy;

  always_comb begin
    st_d     = st_q;
    start    = 1'b0;
    eng_self = 1'b0;
    dec      = 1'b0;
    tmr_clr  = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (pause_q == '0) st_d = ST_INIT;
      ST_INIT: begin
        start = free;
        if (eng_done && icnt_q == IW'(INIT_REFRESHES - 1)) st_d = ST_RUN;
      end
      ST_RUN: if (free) begin
        if (pend != '0) begin start = 1'b1; dec = 1'b1; end
        else if (sr_req_i) st_d = ST_GIN;
      end
      ST_GIN:  begin start = free; if (eng_done) st_d = ST_SELF; end
      ST_SELF: begin start = free; eng_self = 1'b1; if (eng_done) st_d = ST_GOUT; end
      ST_GOUT: begin
        start = free;
        if (eng_done) begin st_d = ST_RUN; tmr_clr = 1'b1; end
      end
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PAUSE;
      pause_q <= PW'(INIT_PAUSE_CYC - 1);
      icnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_PAUSE && pause_q != '0) pause_q <= pause_q - 1'b1;
      if (st_q == ST_INIT && eng_done)       icnt_q  <= icnt_q + 1'b1;
      if (st_q == ST_INIT && st_d == ST_RUN) done_q  <= 1'b1;
    end
  end

  dref_interval_timer #(
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC),
    .PEND_W          (PEND_W)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_RUN),
    .clr_i (tmr_clr),
    .dec_i (dec),
    .pend_o(pend)
  );

  dref_cbr_engine #(
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RAS_CYC     (RAS_CYC),
    .RP_CYC      (RP_CYC),
    .SELF_MIN_CYC(SELF_MIN_CYC),
    .SELF_RP_CYC (SELF_RP_CYC)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .self_i   (eng_self),
    .hold_i   (sr_req_i),
    .busy_o   (busy),
    .done_o   (eng_done),
    .ras_low_o(ras_low),
    .cas_low_o(cas_low)
  );

  assign bus_req_o = busy || (st_q == ST_INIT) || (st_q == ST_GIN) ||
                     (st_q == ST_SELF) || (st_q == ST_GOUT) ||
                     ((st_q == ST_RUN) && (pend != '0 || sr_req_i));
  assign ras_n_o     = !ras_low;
  assign init_done_o = done_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n_o[g] = !cas_low;
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE) |-> (!bus_req_o && ras_n_o && (&cas_n_o))); // R2
  AST_STROBES_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !(&cas_n_o)) |-> bus_req_o); // R11
  AST_START_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(bus_gnt_i)); // R11
  AST_DONE_PRECHARGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (ras_n_o && !busy)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R3
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int LANES = 2, PAUSE = 40, NINIT = 8, IVL = 100, PW = 3;
  localparam int CSR = 2, CHR = 2, RAS = 5, RP = 3, SMIN = 30, SRP = 6;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0, sr = 1'b0;
  logic req, ras_n, done;
  logic [LANES-1:0] cas_n;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .LANES(LANES), .INIT_PAUSE_CYC(PAUSE), .INIT_REFRESHES(NINIT),
    .REF_INTERVAL_CYC(IVL), .PEND_W(PW), .CSR_CYC(CSR), .CHR_CYC(CHR),
    .RAS_CYC(RAS), .RP_CYC(RP), .SELF_MIN_CYC(SMIN), .SELF_RP_CYC(SRP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(gnt), .sr_req_i(sr),
    .bus_req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .init_done_o(done)
  );

  // edge monitor, sampled mid-cycle
  int n_fall = 0, n_rise = 0, cyc = 0, lane_bad = 0;
  int su_run = 0, hi_run = 0, lo_run = 0, ho_run = 0;
  int setup_a[512], hold_a[512], low_a[512], high_a[512], tfall_a[512];
  logic p_ras = 1'b1, p_cl = 1'b0;
  always @(negedge clk) begin
    logic cl;
    cyc++;
    cl = (cas_n == '0);
    if (cas_n != '0 && cas_n != '1) lane_bad++;
    if (p_ras && !ras_n) begin
      setup_a[n_fall % 512] = su_run; high_a[n_fall % 512] = hi_run;
      tfall_a[n_fall % 512] = cyc; n_fall++;
    end
    if (!p_ras && ras_n) begin low_a[n_rise % 512] = lo_run; n_rise++; end
    if (p_cl && !cl && n_fall > 0) hold_a[(n_fall - 1) % 512] = ho_run;
    hi_run = ras_n ? hi_run + 1 : 0;
    lo_run = !ras_n ? lo_run + 1 : 0;
    su_run = (ras_n && cl) ? su_run + 1 : 0;
    ho_run = (!ras_n && cl) ? ho_run + 1 : 0;
    p_ras = ras_n; p_cl = cl;
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wait_req_low();
    for (int i = 0; i < 3000 && req; i++) step();
  endtask

  task automatic t_reset();
    step(3);
    chk(ras_n == 1'b1 && cas_n == '1, "R1 strobes", {ras_n, cas_n}, 7);
    chk(!req && !done, "R1 req/done", {req, done}, 0);
    rst_n = 1'b1;
    step();
    chk(!req && !done && ras_n, "R1 after release", {req, done, ras_n}, 1);
  endtask

  task automatic t_init();
    int bad = 0;
    gnt = 1'b1;
    for (int i = 0; i < PAUSE - 3; i++) begin
      if (req || !ras_n || cas_n != '1) bad++;
      step();
    end
    chk(bad == 0, "R2 quiet pause", bad, 0);
    for (int i = 0; i < 3000 && !done; i++) begin
      if (done) break;
      step();
    end
    chk(done, "R3 init_done raised", done, 1);
    chk(n_fall == NINIT, "R3 init refresh count", n_fall, NINIT);
    chk(ras_n, "R3 precharged at done", ras_n, 1);
    bad = 0;
    for (int i = 0; i < NINIT; i++) begin
      if (setup_a[i] != CSR || hold_a[i] != CHR) bad++;
      if (low_a[i] != RAS || (i > 0 && high_a[i] < RP)) bad++;
    end
    chk(bad == 0, "R4/R5 init cycle shape", bad, 0);
  endtask

  task automatic t_interval();
    int b = n_fall, bad = 0;
    step(IVL * 5 + 20);
    chk(n_fall - b >= 4 && n_fall - b <= 6, "R6 refresh count", n_fall - b, 5);
    for (int i = b + 1; i < n_fall; i++)
      if (tfall_a[i] - tfall_a[i-1] != IVL) bad++;
    chk(bad == 0, "R6 exact spacing", bad, 0);
    bad = 0;
    for (int i = b; i < n_fall; i++)
      if (setup_a[i] != CSR || hold_a[i] != CHR || low_a[i] != RAS || high_a[i] < RP) bad++;
    chk(bad == 0, "R4/R5 timed cycle shape", bad, 0);
    chk(done, "R3 init_done sticky", done, 1);
  endtask

  task automatic t_catchup();
    int b, bad = 0;
    wait_req_low();
    gnt = 1'b0;
    b = n_fall;
    for (int i = 0; i < IVL * 7 / 2; i++) begin
      if (!ras_n || cas_n != '1) bad++;
      step();
    end
    chk(bad == 0, "R7 no strobes without grant", bad, 0);
    chk(req, "R7 request held", req, 1);
    chk(n_fall == b, "R7 no cycles while denied", n_fall - b, 0);
    gnt = 1'b1;
    step(60);
    chk(n_fall - b >= 3 && n_fall - b <= 5, "R7 catch-up count", n_fall - b, 3);
    bad = 0;
    for (int i = b + 1; i < b + 3; i++)
      if (tfall_a[i] - tfall_a[i-1] > RAS + RP + CSR + 2) bad++;
    chk(bad == 0, "R7 back to back", bad, 0);
  endtask

  task automatic t_saturate();
    int b;
    wait_req_low();
    gnt = 1'b0;
    b = n_fall;
    step(IVL * 10);
    gnt = 1'b1;
    step(78);
    chk(n_fall - b >= 7 && n_fall - b <= 8, "R8 saturated backlog", n_fall - b, 7);
  endtask

  task automatic t_self_long();
    int b, bad = 0;
    wait_req_low();
    for (int i = 0; i < 2 * IVL && n_fall == 0; i++) step();
    begin
      int f0 = n_fall;
      for (int i = 0; i < 2 * IVL && n_fall == f0; i++) step();
    end
    wait_req_low();
    b = n_fall;
    sr = 1'b1;
    step(200);
    chk(!ras_n && cas_n == '0, "R9 parked strobes", {ras_n, cas_n}, 0);
    chk(req, "R9 bus held", req, 1);
    sr = 1'b0;
    wait_req_low();
    chk(n_fall - b == 3, "R9/R10 guard+self+guard", n_fall - b, 3);
    chk(low_a[b % 512] == RAS, "R9 entry guard width", low_a[b % 512], RAS);
    chk(low_a[(b+1) % 512] >= SMIN, "R9 self width", low_a[(b+1) % 512], SMIN);
    chk(high_a[(b+2) % 512] >= SRP, "R10 self precharge", high_a[(b+2) % 512], SRP);
    chk(low_a[(b+2) % 512] == RAS && setup_a[(b+2) % 512] == CSR, "R10 exit guard shape",
        low_a[(b+2) % 512], RAS);
    b = n_fall;
    for (int i = 0; i < IVL - 10; i++) begin
      if (n_fall != b) bad++;
      step();
    end
    chk(bad == 0, "R10 timer restarted", n_fall - b, 0);
    step(25);
    chk(n_fall - b == 1, "R10 next timed refresh", n_fall - b, 1);
  endtask

  task automatic t_self_short();
    int b;
    wait_req_low();
    b = n_fall;
    sr = 1'b1;
    for (int i = 0; i < 500 && n_fall < b + 2; i++) step();
    sr = 1'b0;
    wait_req_low();
    chk(low_a[(b+1) % 512] == SMIN, "R9 short request min width", low_a[(b+1) % 512], SMIN);
    chk(lane_bad == 0, "R4 lanes together", lane_bad, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_interval();
    t_catchup();
    t_saturate();
    t_self_long();
    t_self_short();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule